// File: doc/BRIEF.md
# Tagged transmit/receive byte queue pair

This block is the buffering stage between a register interface and a serial bus master engine. It holds two independent 64-entry queues. The transmit queue takes 32-bit register writes; each entry keeps the data byte and an end-of-message tag. The bus engine drains them one at a time. The receive queue is filled by the engine. Each entry holds a received byte, a 2-bit per-byte status code and a checksum error flag. The register side reads these entries back as 32-bit words.

A single control word serves both queues. Writing it can flush either queue, and it sets a receive threshold. Reading it returns the receive occupancy and the programmed threshold. The block drives level indications for full, empty, threshold reached and transmit underrun. Interrupt logic elsewhere turns these into interrupts. A transmit underrun means the engine has run out of bytes while the current message is still open.

Top module: `tagged_byte_fifo_pair`

## Requirements
- R1: Each queue accepts exactly 64 entries before it reports full, and it returns them in the order they were written.
- R2: A transmit write stores bits 7:0 as the byte and bit 31 as the end-of-message tag. Bits 30:8 are ignored. The oldest entry appears on `eng_tx_byte`/`eng_tx_last`, and `eng_tx_pop` removes it.
- R3: A receive read word carries the byte in bits 7:0, the checksum error flag in bit 29 and the 2-bit status in bits 31:30. All other bits are 0. `rx_rd_en` removes the entry.
- R4: A control write with bit 31 set empties the receive queue, and one with bit 30 set empties the transmit queue, both at the same clock edge. The flush wins over a push or pop in that cycle. Both bits read back as 0.
- R5: The control read word holds the receive occupancy in bits 22:16 and the threshold in bits 13:8. All other bits are 0. A control write loads the threshold from bits 13:8.
- R6: `rx_thresh` is 1 whenever the receive occupancy is greater than or equal to the threshold. The threshold is 0 after reset, so the flag is then 1 even when the queue is empty.
- R7: `rx_full`/`tx_full` are 1 exactly when a queue holds 64 entries. `rx_empty`/`tx_empty` are 1 exactly when a queue holds none.
- R8: A transmit write or engine receive push to a full queue is dropped. A receive read or engine pop from an empty queue returns 0. In neither case do the stored contents or the order change.
- R9: `tx_underrun` is 1 exactly when the transmit queue is empty while `eng_more` is 1.
- R10: After reset, both queues are empty, the threshold is 0 and the control read word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_wr_en | input | 1 | Transmit register write strobe |
| tx_wr_word | input | 32 | Transmit write word (byte 7:0, end tag 31) |
| rx_rd_en | input | 1 | Receive register read strobe (pops) |
| rx_rd_word | output | 32 | Oldest receive entry, formatted; 0 when empty |
| ctrl_wr_en | input | 1 | Control word write strobe |
| ctrl_wr_word | input | 32 | Control write word (flushes 31/30, threshold 13:8) |
| ctrl_rd_word | output | 32 | Control read word (occupancy 22:16, threshold 13:8) |
| eng_tx_pop | input | 1 | Engine takes the oldest transmit entry |
| eng_tx_byte | output | 8 | Oldest transmit byte; 0 when empty |
| eng_tx_last | output | 1 | End-of-message tag of the oldest transmit entry |
| eng_tx_avail | output | 1 | Transmit queue holds at least one entry |
| eng_more | input | 1 | Engine still expects bytes of the current message |
| eng_rx_push | input | 1 | Engine stores a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_rx_status | input | 2 | Per-byte status code |
| eng_rx_err | input | 1 | Per-byte checksum error flag |
| tx_full | output | 1 | Transmit queue holds 64 entries |
| tx_empty | output | 1 | Transmit queue holds no entry |
| tx_underrun | output | 1 | Transmit queue empty while the message is still open |
| rx_full | output | 1 | Receive queue holds 64 entries |
| rx_empty | output | 1 | Receive queue holds no entry |
| rx_thresh | output | 1 | Receive occupancy at or above the threshold |

## Verification
A pointer or count that goes wrong becomes visible on the next clock edge. It shows up in the occupancy field of the control read word and in the full, empty and threshold flags. The byte queued next on either side also goes wrong, and the bench compares it on every pop. A dropped or mis-tagged bit in an entry shows in the formatted receive word or the end tag at the moment that entry reaches the head. Flush priority and overflow handling are exercised in the very cycle they conflict with a push or pop. Their effect is checked one cycle later.

// File: rtl/tfp_pkg.sv
// Package: shared widths, field positions and entry types for the
// tagged byte queue pair. Assumes 8-bit payloads and a 32-bit register word.
package tfp_pkg;
    localparam int FIFO_DEPTH   = 64;
    localparam int BYTE_W       = 8;
    localparam int STAT_W       = 2;
    localparam int WORD_W       = 32;

    // transmit write word
    localparam int TX_TAG_BIT   = 31;
    // receive read word
    localparam int RX_STAT_LSB  = 30;
    localparam int RX_ERR_BIT   = 29;
    // control word
    localparam int CW_RXFL_BIT  = 31;
    localparam int CW_TXFL_BIT  = 30;
    localparam int CW_OCC_LSB   = 16;
    localparam int CW_OCC_W     = 7;
    localparam int CW_THR_LSB   = 8;
    localparam int CW_THR_W     = 6;

    typedef struct packed {
        logic              last;
        logic [BYTE_W-1:0] data;
    } tx_entry_t;

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic              err;
        logic [BYTE_W-1:0] data;
    } rx_entry_t;
endpackage

// File: rtl/tfp_fifo.sv
// Module: tfp_fifo
// Synchronous single-clock queue with a flush input. Push to a full queue
// and pop from an empty queue are ignored. Flush clears pointers and count
// at the clock edge and overrides any push or pop in that cycle.
// Assumes: DEPTH >= 2; the head output is only meaningful when not empty.
module tfp_fifo #(
    parameter int ENTRY_W = 9,
    parameter int DEPTH   = 64,
    localparam int AW     = $clog2(DEPTH),
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               push,
    input  logic [ENTRY_W-1:0] push_data,
    input  logic               pop,
    output logic [ENTRY_W-1:0] head,
    output logic [CW-1:0]      count,
    output logic               full,
    output logic               empty
);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [ENTRY_W-1:0] mem [DEPTH];
    logic [AW-1:0]      wptr;
    logic [AW-1:0]      rptr;
    logic               push_ok;
    logic               pop_ok;

    // Purpose: qualify requests against the current occupancy.
    always_comb begin
        full    = (count == FULL_CNT);
        empty   = (count == '0);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        head    = mem[rptr];
    end

    // Purpose: store an accepted entry at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok && !flush) begin
            mem[wptr] <= push_data;
        end
    end

    // Purpose: advance pointers and occupancy, with flush taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) begin
                wptr <= (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
            end
            if (pop_ok) begin
                rptr <= (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R7: occupancy never exceeds the depth
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R4: a flush leaves the queue empty at the next edge
    assert_flush_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0) && (wptr == rptr));

    // R8: a push into a full queue with no pop changes nothing
    assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> $stable(wptr) && $stable(count));

    // R8: a pop from an empty queue with no push changes nothing
    assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> $stable(rptr) && (count == '0));
endmodule

// File: rtl/tfp_ctrl.sv
// Module: tfp_ctrl
// Control word decode: turns flush bits into single-cycle pulses, holds the
// receive threshold, compares it with the receive occupancy and formats the
// control read word. Assumes the occupancy fits the 7-bit read field.
module tfp_ctrl #(
    parameter int CNT_W = 7
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [tfp_pkg::WORD_W-1:0]      wr_word,
    input  logic [CNT_W-1:0]                rx_count,
    output logic                            flush_rx,
    output logic                            flush_tx,
    output logic                            rx_thresh,
    output logic [tfp_pkg::WORD_W-1:0]      rd_word
);
    import tfp_pkg::*;

    logic [CW_THR_W-1:0] thr_q;

    // Purpose: derive self-clearing flush pulses from the write strobe.
    always_comb begin
        flush_rx = wr_en && wr_word[CW_RXFL_BIT];
        flush_tx = wr_en && wr_word[CW_TXFL_BIT];
    end

    // Purpose: hold the programmed receive threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= '0;
        end else if (wr_en) begin
            thr_q <= wr_word[CW_THR_LSB +: CW_THR_W];
        end
    end

    // Purpose: compare occupancy with the threshold and build the read word.
    always_comb begin
        rx_thresh = (rx_count >= CNT_W'(thr_q));
        rd_word   = '0;
        rd_word[CW_OCC_LSB +: CW_OCC_W] = CW_OCC_W'(rx_count);
        rd_word[CW_THR_LSB +: CW_THR_W] = thr_q;
    end

    // R6: an empty queue can only meet a zero threshold
    assert_thresh_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0 && rx_thresh) |-> (rd_word[CW_THR_LSB +: CW_THR_W] == '0));

    // R4: flush bits never read back as set
    assert_flush_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_word[CW_RXFL_BIT] == 1'b0 && rd_word[CW_TXFL_BIT] == 1'b0);
endmodule

// File: rtl/tagged_byte_fifo_pair.sv
// Module: tagged_byte_fifo_pair
// Top: transmit queue (byte + end tag) drained by the bus engine, receive
// queue (byte + status + checksum error) filled by the bus engine, and a
// shared control word. Assumes single-cycle register strobes and that a
// read word is sampled in the same cycle as its read strobe.
module tagged_byte_fifo_pair #(
    parameter int DEPTH = tfp_pkg::FIFO_DEPTH,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_wr_en,
    input  logic [31:0] tx_wr_word,
    input  logic        rx_rd_en,
    output logic [31:0] rx_rd_word,
    input  logic        ctrl_wr_en,
    input  logic [31:0] ctrl_wr_word,
    output logic [31:0] ctrl_rd_word,
    input  logic        eng_tx_pop,
    output logic [7:0]  eng_tx_byte,
    output logic        eng_tx_last,
    output logic        eng_tx_avail,
    input  logic        eng_more,
    input  logic        eng_rx_push,
    input  logic [7:0]  eng_rx_byte,
    input  logic [1:0]  eng_rx_status,
    input  logic        eng_rx_err,
    output logic        tx_full,
    output logic        tx_empty,
    output logic        tx_underrun,
    output logic        rx_full,
    output logic        rx_empty,
    output logic        rx_thresh
);
    import tfp_pkg::*;

    localparam int TX_W = $bits(tx_entry_t);
    localparam int RX_W = $bits(rx_entry_t);

    tx_entry_t        tx_in;
    tx_entry_t        tx_head;
    rx_entry_t        rx_in;
    rx_entry_t        rx_head;
    logic [CNT_W-1:0] tx_count;
    logic [CNT_W-1:0] rx_count;
    logic             flush_rx;
    logic             flush_tx;
    logic             unused_bits;

    // Purpose: pack register and engine inputs into queue entries.
    always_comb begin
        tx_in.data    = tx_wr_word[BYTE_W-1:0];
        tx_in.last    = tx_wr_word[TX_TAG_BIT];
        rx_in.data    = eng_rx_byte;
        rx_in.status  = eng_rx_status;
        rx_in.err     = eng_rx_err;
    end

    assign unused_bits = ^{tx_wr_word[30:8], tx_count,
                           ctrl_wr_word[29:14], ctrl_wr_word[7:0]};

    tfp_fifo #(.ENTRY_W(TX_W), .DEPTH(DEPTH)) u_tx_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_tx),
        .push      (tx_wr_en),
        .push_data (tx_in),
        .pop       (eng_tx_pop),
        .head      (tx_head),
        .count     (tx_count),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    tfp_fifo #(.ENTRY_W(RX_W), .DEPTH(DEPTH)) u_rx_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_rx),
        .push      (eng_rx_push),
        .push_data (rx_in),
        .pop       (rx_rd_en),
        .head      (rx_head),
        .count     (rx_count),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    tfp_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ctrl_wr_en),
        .wr_word   (ctrl_wr_word),
        .rx_count  (rx_count),
        .flush_rx  (flush_rx),
        .flush_tx  (flush_tx),
        .rx_thresh (rx_thresh),
        .rd_word   (ctrl_rd_word)
    );

    // Purpose: present the transmit head to the engine, zero when empty.
    always_comb begin
        eng_tx_avail = !tx_empty;
        eng_tx_byte  = tx_empty ? '0 : tx_head.data;
        eng_tx_last  = !tx_empty && tx_head.last;
        tx_underrun  = tx_empty && eng_more;
    end

    // Purpose: format the receive head as a register word, zero when empty.
    always_comb begin
        rx_rd_word = '0;
        if (!rx_empty) begin
            rx_rd_word[BYTE_W-1:0]               = rx_head.data;
            rx_rd_word[RX_ERR_BIT]               = rx_head.err;
            rx_rd_word[RX_STAT_LSB +: STAT_W]    = rx_head.status;
        end
    end

    // R9: underrun only with an open message and nothing queued
    assert_underrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underrun |-> (eng_more && !eng_tx_avail));

    // R7: full and empty are exclusive on both queues
    assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_full && rx_empty) && !(tx_full && tx_empty));

    // R8: reading an empty receive queue yields zero
    assert_empty_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |-> (rx_rd_word == '0));
endmodule

// File: tb/tb_tagged_byte_fifo_pair.sv
`timescale 1ns/1ps
module tb_tagged_byte_fifo_pair;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tx_wr_en = 0;
    logic [31:0] tx_wr_word = '0;
    logic        rx_rd_en = 0;
    logic [31:0] rx_rd_word;
    logic        ctrl_wr_en = 0;
    logic [31:0] ctrl_wr_word = '0;
    logic [31:0] ctrl_rd_word;
    logic        eng_tx_pop = 0;
    logic [7:0]  eng_tx_byte;
    logic        eng_tx_last;
    logic        eng_tx_avail;
    logic        eng_more = 0;
    logic        eng_rx_push = 0;
    logic [7:0]  eng_rx_byte = '0;
    logic [1:0]  eng_rx_status = '0;
    logic        eng_rx_err = 0;
    logic        tx_full, tx_empty, tx_underrun, rx_full, rx_empty, rx_thresh;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    tagged_byte_fifo_pair dut (.*);

    // {tx write word, expected end tag, expected byte}
    localparam logic [40:0] TX_VEC [5] = '{
        {32'h0000_0011, 1'b0, 8'h11},
        {32'h7FFF_FF22, 1'b0, 8'h22},
        {32'h8000_0033, 1'b1, 8'h33},
        {32'h0000_00A5, 1'b0, 8'hA5},
        {32'hFFFF_FFFF, 1'b1, 8'hFF}
    };
    // {status, err, byte, expected read word}
    localparam logic [42:0] RX_VEC [5] = '{
        {2'b00, 1'b0, 8'h01, 32'h0000_0001},
        {2'b01, 1'b0, 8'h80, 32'h4000_0080},
        {2'b10, 1'b1, 8'h7E, 32'hA000_007E},
        {2'b11, 1'b1, 8'hFF, 32'hE000_00FF},
        {2'b00, 1'b1, 8'h00, 32'h2000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        tx_wr_en = 0; rx_rd_en = 0; ctrl_wr_en = 0; eng_tx_pop = 0; eng_rx_push = 0;
    endtask

    task automatic tx_write(input logic [31:0] w);
        tx_wr_en = 1; tx_wr_word = w; step();
    endtask

    task automatic rx_push(input logic [1:0] s, input logic e, input logic [7:0] b);
        eng_rx_push = 1; eng_rx_status = s; eng_rx_err = e; eng_rx_byte = b; step();
    endtask

    task automatic ctrl_write(input logic [31:0] w);
        ctrl_wr_en = 1; ctrl_wr_word = w; step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R10 reset state
        chk("R10 tx_empty", tx_empty, 1);
        chk("R10 rx_empty", rx_empty, 1);
        chk("R10 ctrl word", ctrl_rd_word, 0);
        chk("R6 zero threshold on empty", rx_thresh, 1);
        chk("R9 no underrun idle", tx_underrun, 0);
        eng_more = 1; #0.1;
        chk("R9 underrun when empty and open", tx_underrun, 1);

        // table walk: write tx words and push rx entries together
        for (int i = 0; i < 5; i++) begin
            tx_wr_en = 1; tx_wr_word = TX_VEC[i][40:9];
            eng_rx_push = 1; eng_rx_status = RX_VEC[i][42:41];
            eng_rx_err = RX_VEC[i][40]; eng_rx_byte = RX_VEC[i][39:32];
            step();
        end
        chk("R9 underrun clears with data", tx_underrun, 0);
        chk("R5 occupancy field", ctrl_rd_word, 32'h0005_0000);
        for (int i = 0; i < 5; i++) begin
            chk("R2 tx byte", {24'h0, eng_tx_byte}, {24'h0, TX_VEC[i][7:0]});
            chk("R2 tx end tag", {31'h0, eng_tx_last}, {31'h0, TX_VEC[i][8]});
            chk("R3 rx word", rx_rd_word, RX_VEC[i][31:0]);
            eng_tx_pop = 1; rx_rd_en = 1; step();
        end
        chk("R7 tx empty after drain", tx_empty, 1);
        chk("R9 underrun after drain", tx_underrun, 1);
        eng_more = 0;

        // R8 empty read returns zero and leaves order intact
        chk("R8 empty read zero", rx_rd_word, 0);
        rx_rd_en = 1; step();
        eng_tx_pop = 1; step();
        chk("R8 empty engine pop zero", {24'h0, eng_tx_byte}, 0);
        rx_push(2'b01, 1'b0, 8'h5A);
        chk("R8 entry after empty read", rx_rd_word, 32'h4000_005A);
        rx_rd_en = 1; step();

        // R1 R7 R8 fill transmit queue and overflow it
        for (int i = 0; i < 64; i++) tx_write(32'(i));
        chk("R7 tx_full at 64", tx_full, 1);
        tx_write(32'h8000_00EE);
        for (int i = 0; i < 64; i++) begin
            chk("R1 R8 tx order after overflow", {24'h0, eng_tx_byte}, 32'(i));
            chk("R8 dropped tag absent", {31'h0, eng_tx_last}, 0);
            eng_tx_pop = 1; step();
        end
        chk("R1 tx empty after 64", tx_empty, 1);

        // R1 R6 R7 R8 fill receive queue
        ctrl_write(32'h0000_3F00);
        chk("R5 threshold field", ctrl_rd_word, 32'h0000_3F00);
        chk("R6 below threshold", rx_thresh, 0);
        for (int i = 0; i < 63; i++) rx_push(2'b00, 1'b0, 8'(i));
        chk("R6 at threshold 63", rx_thresh, 1);
        chk("R7 rx not full at 63", rx_full, 0);
        rx_push(2'b00, 1'b0, 8'd63);
        chk("R7 rx_full at 64", rx_full, 1);
        chk("R5 occupancy 64", ctrl_rd_word, 32'h0040_3F00);
        rx_push(2'b11, 1'b1, 8'hEE);
        chk("R8 overflow push dropped", ctrl_rd_word, 32'h0040_3F00);
        chk("R1 rx head", rx_rd_word, 32'h0);
        rx_rd_en = 1; step();
        chk("R6 still at 63", rx_thresh, 1);
        chk("R1 rx second", rx_rd_word, 32'h1);
        rx_rd_en = 1; step();
        chk("R6 below at 62", rx_thresh, 0);

        // R4 flush RX with simultaneous push and read; TX untouched
        tx_write(32'h0000_0077);
        ctrl_wr_en = 1; ctrl_wr_word = 32'h8000_0000;
        eng_rx_push = 1; rx_rd_en = 1; step();
        chk("R4 rx flushed", rx_empty, 1);
        chk("R4 ctrl after flush", ctrl_rd_word, 32'h0);
        chk("R4 tx kept", {24'h0, eng_tx_byte}, 32'h77);

        // R4 flush TX with simultaneous write
        ctrl_wr_en = 1; ctrl_wr_word = 32'h4000_0000;
        tx_wr_en = 1; tx_wr_word = 32'h0000_0099; step();
        chk("R4 tx flushed", tx_empty, 1);
        tx_write(32'h0000_0042);
        chk("R4 tx usable after flush", {24'h0, eng_tx_byte}, 32'h42);

        finish_run();
    end
endmodule